// File: doc/BRIEF.md
# Serial Display Mirror to VGA Raster

This block shows, on a VGA monitor, the same picture that a microcontroller sends to a small monochrome OLED panel over SPI. It does not take part in the bus. It listens to the clock, data, chip-select and data/command lines, and keeps every data byte in a bit-addressed frame store. The panel's memory is organised in pages. Each byte covers eight vertically stacked pixels of one column, and a page is eight pixel rows high. The store keeps that layout unchanged.

A second clock domain, driven by the pixel clock, produces standard 640x480 timing. It reads the store in raster order and shows each source pixel as a 5x5 block, so the 128x64 source fills a 640x320 area at the top of the screen. A row-start address register and two address rules turn the column-byte layout into a raster scan without a lookup table. One rule steps to the next bit inside a page. The other moves to the next page at a page boundary.

Top module: `oled_vga_mirror`

## Requirements
- R1: The horizontal period is H_TOTAL pixel clocks (800 by default). hsync_o is low for H_SYNC clocks (96), starting at column H_VIS+H_FP (656), and is high otherwise.
- R2: A frame has V_TOTAL lines (525). vsync_o is low for V_SYNC lines (2), starting at line V_VIS+V_FP (490), and is high otherwise.
- R3: video_o is low at every column at or beyond H_VIS (640) and on every line at or beyond the image height V_IMG (320).
- R4: Inside the image, the pixel at line y and column x shows source row y/5 and source column x/5. Every output lags the position counters by one pixel clock.
- R5: The k-th stored data byte since reset goes to page k/SRC_W and column k%SRC_W. Bit b of that byte is source row page*8+b, so the LSB is the top row. A set bit shows as video high.
- R6: Serial bits are taken on the rising SCK edge, MSB first. The byte is stored on its eighth edge.
- R7: A byte is stored only while spi_cs_ni is low and spi_dc_i is high on its eighth edge. Command bytes (spi_dc_i low) leave both the store and the write position unchanged.
- R8: Raising spi_cs_ni discards a partly received byte. Bit counting restarts at the next selected byte, and SCK edges while deselected have no effect.
- R9: After the last byte of the last page, the write position wraps to page 0, column 0.
- R10: While reset is held, hsync_o and vsync_o are high and video_o is low. After reset, every location reads as dark until it has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| spi_sck_i | input | 1 | Snooped serial clock |
| spi_mosi_i | input | 1 | Snooped serial data |
| spi_cs_ni | input | 1 | Snooped chip select, active low |
| spi_dc_i | input | 1 | Snooped data/command select, high for data |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| video_o | output | 1 | Monochrome pixel output |

## Verification
A wrong row-start register or a wrong per-pixel step shows within one image line as shifted or repeated 5-pixel blocks. A wrong page-crossing rule stays hidden until source row 8, which is line 40 of the image, and then shows a whole band taken from the wrong page. A write pointer that is out of step appears as every following byte landing one column off. The bench therefore compares complete frames against a model built from the written bytes, after patterns that contain command bytes, aborted bytes and a pointer wrap.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  localparam int unsigned BYTE_BITS = 8;

  // step the row start: next bit inside a page, or bit 0 of the next page
  function automatic int unsigned next_row_start(int unsigned cur, int unsigned page_bits);
    if (cur % BYTE_BITS == BYTE_BITS - 1) return cur + page_bits - (BYTE_BITS - 1);
    return cur + 1;
  endfunction
endpackage

// File: rtl/mirror_fb_ram.sv
module mirror_fb_ram #(
  parameter int NBYTES = 1024,
  parameter int BW     = 10
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [BW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [BW+2:0] raddr_i,
  output logic          rbit_o
);
  logic [7:0]        mem [NBYTES];
  logic [NBYTES-1:0] vld_q;
  logic [BW-1:0]     rbyte;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[waddr_i] <= 1'b1;
  end

  assign rbyte  = raddr_i[BW+2:3];
  assign rbit_o = vld_q[rbyte] & mem[rbyte][raddr_i[2:0]];
endmodule

// File: rtl/mirror_spi_rx.sv
module mirror_spi_rx #(
  parameter int NBYTES = 1024,
  parameter int BW     = 10
) (
  input  logic          sck_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          dc_i,
  input  logic          mosi_i,
  output logic          we_o,
  output logic [BW-1:0] waddr_o,
  output logic [7:0]    wdata_o
);
  localparam logic [BW-1:0] LAST = BW'(NBYTES - 1);

  logic       sel_rst_n;
  logic [2:0] bit_cnt_q;
  logic [6:0] shift_q;
  logic [BW-1:0] wptr_q;

  // deselect clears any partial byte at once
  assign sel_rst_n = rst_ni & ~cs_ni;

  always_ff @(posedge sck_i or negedge sel_rst_n) begin
    if (!sel_rst_n) begin
      bit_cnt_q <= '0;
      shift_q   <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      shift_q   <= {shift_q[5:0], mosi_i};
    end
  end

  assign we_o    = ~cs_ni & dc_i & (bit_cnt_q == 3'd7);
  assign wdata_o = {shift_q, mosi_i};
  assign waddr_o = wptr_q;

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni)   wptr_q <= '0;
    else if (we_o) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + BW'(1);
  end
endmodule

// File: rtl/mirror_vga_timing.sv
module mirror_vga_timing #(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_TOTAL = 800,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_TOTAL = 525,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          frame_end_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] HS_BEG = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          line_wrap;

  assign line_wrap = (hcnt_q == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (line_wrap) begin
      hcnt_q <= '0;
      vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + VW'(1);
    end else begin
      hcnt_q <= hcnt_q + HW'(1);
    end
  end

  assign hcnt_o      = hcnt_q;
  assign vcnt_o      = vcnt_q;
  assign hsync_n_o   = ~((hcnt_q >= HS_BEG) && (hcnt_q < HS_END));
  assign vsync_n_o   = ~((vcnt_q >= VS_BEG) && (vcnt_q < VS_END));
  assign frame_end_o = line_wrap && (vcnt_q == V_LAST);
endmodule

// File: rtl/mirror_raster_addr.sv
module mirror_raster_addr #(
  parameter int SCALE     = 5,
  parameter int PAGE_BITS = 1024,
  parameter int AW        = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_end_i,
  input  logic          line_end_i,
  input  logic          pix_active_i,
  output logic [AW-1:0] raddr_o
);
  localparam int SW = (SCALE > 1) ? $clog2(SCALE) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(SCALE - 1);

  logic [SW-1:0] hsub_q, vsub_q;
  logic [AW-1:0] row_start_q, raddr_q, row_next;

  assign row_next = AW'(mirror_pkg::next_row_start(32'(row_start_q), PAGE_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsub_q      <= '0;
      vsub_q      <= '0;
      row_start_q <= '0;
      raddr_q     <= '0;
    end else if (frame_end_i) begin
      hsub_q      <= '0;
      vsub_q      <= '0;
      row_start_q <= '0;
      raddr_q     <= '0;
    end else if (line_end_i) begin
      hsub_q <= '0;
      if (vsub_q == SUB_LAST) begin
        vsub_q      <= '0;
        row_start_q <= row_next;
        raddr_q     <= row_next;
      end else begin
        vsub_q  <= vsub_q + SW'(1);
        raddr_q <= row_start_q;
      end
    end else if (pix_active_i) begin
      if (hsub_q == SUB_LAST) begin
        hsub_q  <= '0;
        raddr_q <= raddr_q + AW'(mirror_pkg::BYTE_BITS);
      end else begin
        hsub_q <= hsub_q + SW'(1);
      end
    end
  end

  assign raddr_o = raddr_q;
endmodule

// File: rtl/oled_vga_mirror.sv
module oled_vga_mirror #(
  parameter int SRC_W  = 128,
  parameter int SRC_H  = 64,
  parameter int SCALE  = 5,
  parameter int V_VIS  = 480,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic spi_sck_i,
  input  logic spi_mosi_i,
  input  logic spi_cs_ni,
  input  logic spi_dc_i,
  output logic hsync_o,
  output logic vsync_o,
  output logic video_o
);
  localparam int H_VIS     = SRC_W * SCALE;
  localparam int H_TOTAL   = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_IMG     = SRC_H * SCALE;
  localparam int V_TOTAL   = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW        = $clog2(H_TOTAL);
  localparam int VW        = $clog2(V_TOTAL);
  localparam int PAGES     = SRC_H / mirror_pkg::BYTE_BITS;
  localparam int NBYTES    = SRC_W * PAGES;
  localparam int BW        = $clog2(NBYTES);
  localparam int AW        = BW + 3;
  localparam int PAGE_BITS = SRC_W * mirror_pkg::BYTE_BITS;
  localparam logic [HW-1:0] H_IMG_END  = HW'(H_VIS);
  localparam logic [HW-1:0] H_IMG_LAST = HW'(H_VIS - 1);
  localparam logic [VW-1:0] V_IMG_END  = VW'(V_IMG);

  logic          we;
  logic [BW-1:0] waddr;
  logic [7:0]    wdata;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          hsync_n, vsync_n, frame_end;
  logic          img_line, pix_active, line_end;
  logic [AW-1:0] raddr;
  logic          rbit;

  mirror_spi_rx #(.NBYTES(NBYTES), .BW(BW)) u_rx (
    .sck_i  (spi_sck_i),
    .rst_ni (rst_ni),
    .cs_ni  (spi_cs_ni),
    .dc_i   (spi_dc_i),
    .mosi_i (spi_mosi_i),
    .we_o   (we),
    .waddr_o(waddr),
    .wdata_o(wdata)
  );

  mirror_fb_ram #(.NBYTES(NBYTES), .BW(BW)) u_ram (
    .wclk_i (spi_sck_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rbit_o (rbit)
  );

  mirror_vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_TOTAL(H_TOTAL),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_TOTAL(V_TOTAL),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hcnt_o     (hcnt),
    .vcnt_o     (vcnt),
    .hsync_n_o  (hsync_n),
    .vsync_n_o  (vsync_n),
    .frame_end_o(frame_end)
  );

  assign img_line   = (vcnt < V_IMG_END);
  assign pix_active = img_line && (hcnt < H_IMG_END);
  assign line_end   = img_line && (hcnt == H_IMG_LAST);

  mirror_raster_addr #(.SCALE(SCALE), .PAGE_BITS(PAGE_BITS), .AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .line_end_i  (line_end),
    .pix_active_i(pix_active),
    .raddr_o     (raddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      video_o <= 1'b0;
    end else begin
      hsync_o <= hsync_n;
      vsync_o <= vsync_n;
      video_o <= pix_active & rbit;
    end
  end
endmodule

// File: rtl/oled_vga_mirror_checker.sv
module oled_vga_mirror_checker #(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_TOTAL  = 800,
  parameter int V_IMG    = 320,
  parameter int V_TOTAL  = 525,
  parameter int VS_START = 490,
  parameter int SCALE    = 5,
  parameter int HW       = 10,
  parameter int VW       = 10,
  parameter int AW       = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic [AW-1:0] raddr,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          video_o
);
  logic [AW-1:0] line_base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_base_q <= '0;
    else if (hcnt == '0 && 32'(vcnt) < V_IMG) line_base_q <= raddr;
  end

  assert_hcnt_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) == H_TOTAL - 1) |=> (hcnt == '0));

  assert_hsync_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) == H_VIS + H_FP) |=> !hsync_o);

  assert_vsync_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(vcnt) == VS_START && hcnt == '0) |=> !vsync_o);

  assert_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) >= H_VIS || 32'(vcnt) >= V_IMG) |=> !video_o);

  assert_pixel_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) < H_VIS - 1 && 32'(vcnt) < V_IMG && (32'(hcnt) % SCALE) == SCALE - 1)
    |=> (raddr == $past(raddr) + AW'(8)));

  assert_line_repeat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) == H_VIS - 1 && 32'(vcnt) < V_IMG && (32'(vcnt) % SCALE) != SCALE - 1)
    |=> (raddr == $past(line_base_q)));

  assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) == H_VIS - 1 && 32'(vcnt) < V_IMG && (32'(vcnt) % SCALE) == SCALE - 1
     && line_base_q[2:0] != 3'd7)
    |=> (raddr == $past(line_base_q) + AW'(1)));

  assert_frame_origin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hcnt) == H_TOTAL - 1 && 32'(vcnt) == V_TOTAL - 1) |=> (raddr == '0));
endmodule

bind oled_vga_mirror oled_vga_mirror_checker #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_TOTAL(H_TOTAL), .V_IMG(V_IMG), .V_TOTAL(V_TOTAL),
  .VS_START(V_VIS + V_FP), .SCALE(SCALE), .HW(HW), .VW(VW), .AW(AW)
) u_oled_vga_mirror_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hcnt   (hcnt),
  .vcnt   (vcnt),
  .raddr  (raddr),
  .hsync_o(hsync_o),
  .vsync_o(vsync_o),
  .video_o(video_o)
);

// File: tb/oled_vga_mirror_bench.sv
module oled_vga_mirror_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 7;
  localparam int SW   = 16;
  localparam int SH   = 16;
  localparam int SC   = 5;
  localparam int VVIS = 90;
  localparam int HFP  = 4;
  localparam int HSY  = 8;
  localparam int HBP  = 4;
  localparam int VFP  = 2;
  localparam int VSY  = 2;
  localparam int VBP  = 3;
  localparam int HVIS = SW * SC;
  localparam int HT   = HVIS + HFP + HSY + HBP;
  localparam int VIMG = SH * SC;
  localparam int VT   = VVIS + VFP + VSY + VBP;
  localparam int NB   = SW * SH / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1, dc = 1'b0;
  logic hsync, vsync, video;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] model [NB];
  int wp = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  oled_vga_mirror #(
    .SRC_W(SW), .SRC_H(SH), .SCALE(SC), .V_VIS(VVIS),
    .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)
  ) u_oled_vga_mirror (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sck_i(sck), .spi_mosi_i(mosi), .spi_cs_ni(cs_n), .spi_dc_i(dc),
    .hsync_o(hsync), .vsync_o(vsync), .video_o(video)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic src_pix(int row, int col);
    return model[(row / 8) * SW + col][row % 8];
  endfunction

  // clocks out the top n bits of b, MSB first
  task automatic send_bits(input logic d, input logic [7:0] b, input int n);
    dc = d;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      #SCK_HALF sck = 1'b1;
      #SCK_HALF sck = 1'b0;
    end
  endtask

  task automatic send_data(input logic [7:0] b);
    send_bits(1'b1, b, 8);
    model[wp] = b;
    wp = (wp + 1) % NB;
  endtask

  // lock to the vsync rise, then compare one full frame position by position
  task automatic scan_frame(input string vid_req);
    logic prev;
    int lv, lh, bad_v, bad_h, bad_s, found;
    int av, ev, ah, eh, as, es;
    bit ev_b, eh_b, es_b;
    bad_v = 0; bad_h = 0; bad_s = 0; found = 0;
    av = 0; ev = 0; ah = 0; eh = 0; as = 0; es = 0;
    @(negedge clk) prev = vsync;
    for (int k = 0; k < 3 * HT * VT; k++) begin
      @(negedge clk);
      if (!prev && vsync) begin found = 1; break; end
      prev = vsync;
    end
    check(found == 1, "R2", "vsync rising edge seen", found, 1);
    if (found == 0) return;
    lv = VVIS + VFP + VSY;
    lh = 0;
    for (int n = 0; n < HT * VT; n++) begin
      eh_b = !(lh >= HVIS + HFP && lh < HVIS + HFP + HSY);
      es_b = !(lv >= VVIS + VFP && lv < VVIS + VFP + VSY);
      ev_b = (lv < VIMG && lh < HVIS) ? src_pix(lv / SC, lh / SC) : 1'b0;
      if (hsync !== eh_b && bad_h == 0) begin bad_h = 1; ah = hsync; eh = eh_b; end
      if (vsync !== es_b && bad_s == 0) begin bad_s = 1; as = vsync; es = es_b; end
      if (video !== ev_b && bad_v == 0) begin
        bad_v = 1; av = video; ev = ev_b;
        $display("  first video mismatch at line %0d column %0d", lv, lh);
      end
      @(negedge clk);
      lh++;
      if (lh == HT) begin lh = 0; lv = (lv + 1) % VT; end
    end
    check(bad_h == 0, "R1", "hsync over frame", ah, eh);
    check(bad_s == 0, "R2", "vsync over frame", as, es);
    check(bad_v == 0, vid_req, "video over frame", av, ev);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NB; i++) model[i] = 8'h00;
    #(CLK_PERIOD * 3);
    check(hsync === 1'b1, "R10", "hsync in reset", hsync, 1);
    check(vsync === 1'b1, "R10", "vsync in reset", vsync, 1);
    check(video === 1'b0, "R10", "video in reset", video, 0);
    @(negedge clk) rst_n = 1'b1;
    scan_frame("R10 R3 dark store");
  endtask

  task automatic t_full_frame();
    cs_n = 1'b0;
    for (int k = 0; k < NB; k++) send_data(8'((k * 29 + 83) ^ (k << 3)));
    cs_n = 1'b1;
    check(wp == 0, "R9", "bench pointer wrapped", wp, 0);
    scan_frame("R4 R5 R6 full pattern");
  endtask

  task automatic t_commands();
    cs_n = 1'b0;
    send_bits(1'b0, 8'hFF, 8);
    send_bits(1'b0, 8'hA5, 8);
    send_bits(1'b0, 8'hFF, 8);
    send_data(8'h00);
    send_data(8'h81);
    cs_n = 1'b1;
    scan_frame("R7 R9 commands skipped, wrap to origin");
  endtask

  task automatic t_cs_abort();
    cs_n = 1'b0;
    send_bits(1'b1, 8'hFF, 5);
    cs_n = 1'b1;
    #SCK_HALF;
    send_bits(1'b1, 8'hFF, 8);
    cs_n = 1'b0;
    #SCK_HALF;
    send_data(8'h5A);
    send_data(8'h3C);
    cs_n = 1'b1;
    scan_frame("R8 R6 partial byte discarded");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_frame();
    t_commands();
    t_cs_abort();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule